// File: doc/BRIEF.md
# Centisecond Stopwatch Core

This core keeps elapsed time as six BCD digits: tens and units of minutes, tens and units of seconds, and tenths and hundredths of a second. Everything runs on one system clock. A prescaler derives single-cycle strobes from that clock: a 100 Hz count strobe and a 25 Hz button-sampling strobe. The two button inputs are raw levels. The core samples them on the slow strobe and turns each rising sample into a one-cycle pulse.

A start/stop press toggles a run flag, which works like the crown of a mechanical stopwatch. A clear press always wins. It stops the count and zeroes every digit at once, whether the watch is running or stopped. While the flag is set, each count strobe adds one hundredth of a second. The digit chain mixes radices: units digits count to nine and tens-of-seconds counts to five. A digit moves on only when the digit below it is enabled and about to wrap. After the full-scale value the count rolls over to zero.

The asynchronous active-low reset is released through a two-stage synchronizer. After release, the core starts stopped and at zero.

Top module: `stopwatch_core`

## Requirements
- R1: While reset is held, and after it is released, all six digit outputs are 0 and `running_o` is 0.
- R2: While running, the time value grows by exactly one hundredth on each count strobe, and count strobes come every CLK_HZ/TICK_HZ clock cycles.
- R3: The hundredths, tenths, seconds-units and minutes-units digits count 0 to 9. The seconds-tens digit counts 0 to 5. A digit advances only when every lower digit wraps in the same step, so 00:59.99 is followed by 01:00.00.
- R4: The core samples each button once per key strobe. The key strobe falls on every (TICK_HZ/KEY_HZ)-th count strobe. A sample of 1 after a sample of 0 makes a single-cycle pulse in the next cycle. A start/stop pulse flips `running_o`. A button held across many strobes acts once.
- R5: A clear pulse sets `running_o` to 0 and all digits to 0 on the next clock edge, whatever the state. If a start/stop pulse falls in the same cycle, it is ignored.
- R6: While `running_o` is 0, the digit outputs do not change, except through a clear.
- R7: When the count is at full scale while running, the next count strobe wraps every digit to 0 and counting continues. Full scale is MIN_TENS_MAX, then 9:59.99; by default that is 59:59.99.
- R8: A button level that rises and falls again between two key strobes has no effect on `running_o` or the digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| btn_toggle | input | 1 | Raw start/stop button level |
| btn_clear | input | 1 | Raw clear button level |
| hund_o | output | 4 | BCD hundredths of a second |
| tenth_o | output | 4 | BCD tenths of a second |
| sec_o | output | 4 | BCD seconds units |
| sec_tens_o | output | 4 | BCD seconds tens (0 to 5) |
| min_o | output | 4 | BCD minutes units |
| min_tens_o | output | 4 | BCD minutes tens |
| running_o | output | 1 | Current run state |

## Verification
The bench drives the count past the seconds-to-minutes boundary. A chain that lets a tens digit reach six, or that carries on an ungated wrap, shows the wrong minute there. It presses clear and start/stop in the same sampling window. A design that gave start/stop priority would be left running. A one-cycle blip placed between key strobes, and a button held across many strobes, expose edge detection that samples on every clock or that fires on a level. The run is taken through the full-scale rollover with a reduced top digit. A design that freezes or saturates there, instead of wrapping to zero, fails the comparison.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DIGITS = 6;
  typedef logic [3:0] bcd_t;

  // Wrap value of each digit, lowest digit first.
  function automatic bcd_t digit_limit(input int idx, input int top_max);
    case (idx)
      3:       return 4'd5;
      5:       return bcd_t'(top_max);
      default: return 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
  parameter int TICK_DIV = 500000,
  parameter int KEY_DIV  = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic key_o
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int KW = (KEY_DIV > 1) ? $clog2(KEY_DIV) : 1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic [KW-1:0] sub_q, sub_d;
  logic          tick_w, key_w;

  assign tick_w = (cnt_q == TW'(TICK_DIV - 1));
  assign key_w  = tick_w && (sub_q == KW'(KEY_DIV - 1));

  always_comb begin
    cnt_d = tick_w ? '0 : cnt_q + 1'b1;
    sub_d = sub_q;
    if (tick_w) sub_d = key_w ? '0 : sub_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sub_q <= sub_d;
    end
  end

  assign tick_o = tick_w;
  assign key_o  = key_w;
endmodule

// File: rtl/sw_edge_pulse.sv
module sw_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic key_i,
  input  logic btn_i,
  output logic pulse_o
);
  logic samp_q, samp_d;
  logic pulse_q, pulse_d;

  always_comb begin
    samp_d  = key_i ? btn_i : samp_q;
    pulse_d = key_i && btn_i && !samp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      samp_q  <= samp_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/sw_digit.sv
module sw_digit
  import sw_pkg::*;
#(
  parameter bcd_t LIMIT = 4'd9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output bcd_t q_o,
  output logic carry_o
);
  bcd_t q_q, q_d;
  logic at_top;

  assign at_top = (q_q == LIMIT);

  always_comb begin
    q_d = q_q;
    if (clr_i)     q_d = '0;
    else if (en_i) q_d = at_top ? '0 : q_q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o     = q_q;
  assign carry_o = en_i && at_top;
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
  import sw_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int TICK_HZ      = 100,
  parameter int KEY_HZ       = 25,
  parameter int MIN_TENS_MAX = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_toggle,
  input  logic       btn_clear,
  output logic [3:0] hund_o,
  output logic [3:0] tenth_o,
  output logic [3:0] sec_o,
  output logic [3:0] sec_tens_o,
  output logic [3:0] min_o,
  output logic [3:0] min_tens_o,
  output logic       running_o
);
  localparam int TICK_DIV = CLK_HZ / TICK_HZ;
  localparam int KEY_DIV  = TICK_HZ / KEY_HZ;

  // reset synchronizer: asserts at once, releases after two edges
  logic rs1_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_n_s <= rs1_q;
    end
  end

  logic tick_stb, key_stb, clr_pulse, tgl_pulse;

  sw_prescaler #(.TICK_DIV(TICK_DIV), .KEY_DIV(KEY_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .tick_o(tick_stb), .key_o(key_stb));

  sw_edge_pulse u_clr (
    .clk(clk), .rst_n(rst_n_s), .key_i(key_stb), .btn_i(btn_clear), .pulse_o(clr_pulse));
  sw_edge_pulse u_tgl (
    .clk(clk), .rst_n(rst_n_s), .key_i(key_stb), .btn_i(btn_toggle), .pulse_o(tgl_pulse));

  // run control: clear has priority over toggle
  logic run_q, run_d;
  always_comb begin
    run_d = run_q;
    if (clr_pulse)      run_d = 1'b0;
    else if (tgl_pulse) run_d = !run_q;
  end
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) run_q <= 1'b0;
    else          run_q <= run_d;
  end

  // cascaded digit chain
  bcd_t              dig_q [DIGITS];
  logic [DIGITS-1:0] en_chain;
  logic [DIGITS-1:0] carry;

  assign en_chain[0] = run_q && tick_stb;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    if (i > 0) begin : g_link
      assign en_chain[i] = carry[i-1];
    end
    sw_digit #(.LIMIT(digit_limit(i, MIN_TENS_MAX))) u_d (
      .clk(clk), .rst_n(rst_n_s), .clr_i(clr_pulse), .en_i(en_chain[i]),
      .q_o(dig_q[i]), .carry_o(carry[i]));
  end

  assign hund_o     = dig_q[0];
  assign tenth_o    = dig_q[1];
  assign sec_o      = dig_q[2];
  assign sec_tens_o = dig_q[3];
  assign min_o      = dig_q[4];
  assign min_tens_o = dig_q[5];
  assign running_o  = run_q;
endmodule

// File: rtl/stopwatch_core_checker.sv
module stopwatch_core_checker (
  input logic        clk,
  input logic        rst_ns,
  input logic        clr_p,
  input logic        tgl_p,
  input logic        tick,
  input logic        wrap,
  input logic        running,
  input logic [23:0] dig
);
  // R5: clear zeroes and stops on the next edge
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    clr_p |=> (dig == 24'h0 && !running));

  // R4: a lone toggle pulse flips the run state
  p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (tgl_p && !clr_p) |=> (running != $past(running)));

  // R6: a stopped watch keeps its digits
  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (!running && !clr_p) |=> $stable(dig));

  // R2: each count strobe while running changes the value
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (running && tick && !clr_p) |=> !$stable(dig));

  // R3: every digit stays in its radix
  p_digit_range_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (dig[3:0] <= 4'd9 && dig[7:4] <= 4'd9 && dig[11:8] <= 4'd9 &&
     dig[15:12] <= 4'd5 && dig[19:16] <= 4'd9));

  // R7: top carry out means the whole value returns to zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (wrap && !clr_p) |=> (dig == 24'h0));
endmodule

bind stopwatch_core stopwatch_core_checker u_chk (
  .clk(clk), .rst_ns(rst_n_s), .clr_p(clr_pulse), .tgl_p(tgl_pulse),
  .tick(tick_stb), .wrap(carry[5]), .running(running_o),
  .dig({min_tens_o, min_o, sec_tens_o, sec_o, tenth_o, hund_o}));

// File: tb/stopwatch_core_bench.sv
`timescale 1ns/1ps
module stopwatch_core_bench;
  localparam int CLK_HZ = 200, TICK_HZ = 100, KEY_HZ = 25, TOP = 0;
  localparam int TDIV = CLK_HZ / TICK_HZ;
  localparam int KDIV = TICK_HZ / KEY_HZ;
  localparam int FULL = (TOP + 1) * 60000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, btn_toggle, btn_clear;
  logic [3:0] hund_o, tenth_o, sec_o, sec_tens_o, min_o, min_tens_o;
  logic running_o;

  stopwatch_core #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .KEY_HZ(KEY_HZ),
                   .MIN_TENS_MAX(TOP)) u_stopwatch_core (
    .clk(clk), .rst_n(rst_n), .btn_toggle(btn_toggle), .btn_clear(btn_clear),
    .hund_o(hund_o), .tenth_o(tenth_o), .sec_o(sec_o), .sec_tens_o(sec_tens_o),
    .min_o(min_o), .min_tens_o(min_tens_o), .running_o(running_o));

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R1";

  task automatic check(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  // behavioural reference model
  int  m_cnt, m_sub, m_total;
  bit  m_rs1, m_rs2, m_sc, m_st, m_pc, m_pt, m_run, m_wrapped, m_key_last;
  always @(posedge clk) begin
    bit tick, key, npc, npt;
    cyc++;
    m_wrapped = 0;
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_cnt = 0; m_sub = 0; m_sc = 0; m_st = 0;
      m_pc = 0; m_pt = 0; m_run = 0; m_total = 0; m_key_last = 0;
    end else if (!m_rs2) begin
      m_rs2 = m_rs1; m_rs1 = 1;
    end else begin
      tick = (m_cnt == TDIV - 1);
      key  = tick && (m_sub == KDIV - 1);
      npc  = key && btn_clear && !m_sc;
      npt  = key && btn_toggle && !m_st;
      if (key) begin m_sc = btn_clear; m_st = btn_toggle; end
      if (m_pc) begin
        m_total = 0; m_run = 0;
      end else begin
        if (m_run && tick) begin
          m_total = (m_total + 1) % FULL;
          m_wrapped = (m_total == 0);
        end
        if (m_pt) m_run = !m_run;
      end
      if (tick) m_sub = (m_sub == KDIV - 1) ? 0 : m_sub + 1;
      m_cnt = tick ? 0 : m_cnt + 1;
      m_pc = npc; m_pt = npt; m_key_last = key;
    end
  end

  function automatic logic [23:0] to_bcd(input int t);
    int cs = t % 100, s = (t / 100) % 60, m = t / 6000;
    return {4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10), 4'(cs / 10), 4'(cs % 10)};
  endfunction

  wire [23:0] dut_dig = {min_tens_o, min_o, sec_tens_o, sec_o, tenth_o, hund_o};

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    check(phase, "running", running_o, m_run);
    check(phase, "digits", dut_dig, to_bcd(m_total));
  end

  always @(posedge clk) if (cyc == 190000) begin
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input bit tgl, input bit clr, input int hold);
    #1; btn_toggle = tgl; btn_clear = clr;
    wait_neg(hold);
    #1; btn_toggle = 0; btn_clear = 0;
    wait_neg(hold);
  endtask

  initial begin
    logic [23:0] snap;
    int gap;
    rst_n = 0; btn_toggle = 0; btn_clear = 0;
    wait_neg(4);
    check("R1", "reset digits", dut_dig, 24'h0);
    check("R1", "reset running", running_o, 0);
    #1 rst_n = 1;
    wait_neg(10);
    check("R1", "post-release digits", dut_dig, 24'h0);
    check("R1", "post-release running", running_o, 0);

    phase = "R4";
    press(1, 0, 40);   // held across several strobes: one toggle only
    check("R4", "held press starts once", running_o, 1);

    phase = "R2";
    @(negedge clk);
    snap = dut_dig;
    while (dut_dig == snap) @(negedge clk);
    snap = dut_dig; gap = 0;
    while (dut_dig == snap) begin @(negedge clk); gap++; end
    check("R2", "cycles per hundredth", gap, TDIV);

    phase = "R3";
    while (m_total != 6000) @(negedge clk);
    check("R3", "minute rollover", dut_dig, 24'h010000);

    phase = "R4";
    press(1, 0, 12);
    check("R4", "second press stops", running_o, 0);

    phase = "R6";
    snap = dut_dig;
    wait_neg(200);
    check("R6", "stopped digits hold", dut_dig, snap);

    phase = "R8";
    while (!m_key_last) @(negedge clk);
    #1 btn_toggle = 1;
    @(negedge clk);
    #1 btn_toggle = 0;
    wait_neg(30);
    check("R8", "blip between strobes ignored", running_o, 0);
    check("R8", "blip leaves digits", dut_dig, snap);

    phase = "R5";
    press(1, 0, 12);
    wait_neg(100);
    check("R5", "running before clear", running_o, 1);
    press(1, 1, 12);   // clear and start/stop together: clear wins
    check("R5", "clear stops", running_o, 0);
    check("R5", "clear zeroes", dut_dig, 24'h0);

    phase = "R7";
    press(1, 0, 12);
    while (!m_wrapped) @(negedge clk);
    check("R7", "wrap to zero", dut_dig, 24'h0);
    check("R7", "keeps running after wrap", running_o, 1);
    wait_neg(20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule